// File: doc/BRIEF.md
# Lane Parity Checker and Generator

This block guards a 36-bit data port that is split into four 9-bit byte lanes. In each lane the top bit carries parity for the eight bits below it. On the incoming side, the block checks every lane that the current bus width actually uses. It drives an active-low error flag whenever one of those lanes has the wrong parity. A single select input chooses odd or even parity for both checking and generation.

On the outgoing side, read data passes through unchanged unless generation is enabled. When it is enabled, the top bit of every lane is overwritten with freshly computed parity. The mailbox read path shares the parity trees with the checker. For that reason the error flag is held inactive whenever a mailbox read with generation is set up.

A parameter picks how the flag is delivered. It can be purely combinational, or it can pass through one register, which adds exactly one clock of latency and resets to the inactive level. Deciding which lanes are active belongs to the surrounding bus-sizing logic; this block only receives the resulting lane mask.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k occupies bits 9k+8 down to 9k, and bit 9k+8 is its parity bit. With `odd_sel` = 1, a lane passes when its nine bits hold an odd number of ones.
- R2: With `odd_sel` = 0, a lane passes when its nine bits hold an even number of ones.
- R3: `perr_n` is 0 when at least one lane whose `lane_en` bit is 1 fails parity, and 1 when every enabled lane passes.
- R4: A lane whose `lane_en` bit k is 0 never affects `perr_n`. With `lane_en` = 0000, `perr_n` is 1 for any bus value.
- R5: With `gen_en` = 1, bit 9k+8 of `rd_data_out` is the parity of `rd_data_in[9k+7:9k]`. For odd parity it is the inverted XOR of those eight bits; for even parity it is their plain XOR. This applies to all four lanes.
- R6: The eight data bits of every lane always pass from `rd_data_in` to `rd_data_out` unchanged. With `gen_en` = 0, the parity bits pass unchanged as well.
- R7: When `mbox_rd` = 1 and `gen_en` = 1 together, `perr_n` is 1 whatever the bus holds. `mbox_rd` alone, or `gen_en` alone, does not mask errors.
- R8: With `REG_FLAG` = 1, `perr_n` shows the result for the inputs of the previous clock. While `rst_n` is 0, it is held at 1.
- R9: With `REG_FLAG` = 0, `perr_n` follows the inputs in the same cycle and does not depend on `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag variant and for the checks |
| rst_n | input | 1 | Active-low reset of the flag register |
| chk_bus | input | 36 | Incoming bus value to be checked |
| rd_data_in | input | 36 | Read data before parity insertion |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| gen_en | input | 1 | Enables parity generation on read data |
| lane_en | input | 4 | Bit k set means lane k is used by the bus width |
| mbox_rd | input | 1 | A mailbox read is set up |
| perr_n | output | 1 | Active-low parity error flag |
| rd_data_out | output | 36 | Read data with parity inserted when enabled |

## Verification
The in-line properties check several rules on every clock:
- every generated lane carries the selected parity, and the data bits are never altered;
- a mailbox read with generation always leaves the flag inactive, and an empty lane mask never reports an error;
- in the registered variant, an error seen by the comparison logic appears on the flag one clock later.

Some behaviour is only visible through the bench's scenarios. This covers which exact lane-mask and fault combinations produce an error under each parity sense, the flag held inactive during reset, and the contrast between mailbox select alone and mailbox select with generation.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sense_e;

   localparam int unsigned DEF_LANES  = 4;
   localparam int unsigned DEF_LANE_W = 9;

   // Level driven on the active-low flag when nothing is wrong.
   localparam logic FLAG_IDLE = 1'b1;

endpackage

// File: rtl/lp_lane_check.sv
module lp_lane_check #(
   parameter int unsigned LANE_W = 9
) (
   input  logic [LANE_W-1:0] lane_bits,
   input  logic              odd_sel,
   input  logic              lane_used,
   output logic              lane_bad
);
   // The reduction XOR of all bits is 1 when the count of ones is odd.
   logic ones_odd;

   always_comb begin
      ones_odd = ^lane_bits;
      lane_bad = lane_used & (ones_odd != odd_sel);
   end
endmodule

// File: rtl/lp_lane_gen.sv
module lp_lane_gen #(
   parameter int unsigned LANE_W = 9
) (
   input  logic [LANE_W-1:0] lane_in,
   input  logic              odd_sel,
   input  logic              gen_en,
   output logic [LANE_W-1:0] lane_out
);
   localparam int unsigned DW = LANE_W - 1;

   logic par_bit;

   always_comb begin
      // Odd: inverted XOR of the data bits. Even: plain XOR.
      par_bit  = (^lane_in[DW-1:0]) ^ odd_sel;
      lane_out = {gen_en ? par_bit : lane_in[DW], lane_in[DW-1:0]};
   end
endmodule

// File: rtl/lp_flag_stage.sv
module lp_flag_stage
   import lane_parity_pkg::*;
#(
   parameter bit REG_FLAG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_bad,
   input  logic mask_err,
   output logic flag_n
);
   logic flag_next;

   always_comb flag_next = mask_err ? FLAG_IDLE : ~any_bad;

   generate
      if (REG_FLAG) begin : g_reg
         logic flag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= FLAG_IDLE;
            else        flag_q <= flag_next;
         end
         assign flag_n = flag_q;

         // R8: an unmasked error reaches the flag exactly one clock later
         assert_reg_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (any_bad && !mask_err) |=> !flag_n);
         assert_reg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_bad || mask_err) |=> flag_n);
      end else begin : g_comb
         assign flag_n = flag_next;

         // R9: no delay between the lane results and the flag
         assert_comb_now_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (any_bad && !mask_err) |-> !flag_n);
      end
   endgenerate
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
   import lane_parity_pkg::*;
#(
   parameter int unsigned LANES    = DEF_LANES,
   parameter int unsigned LANE_W   = DEF_LANE_W,
   parameter bit          REG_FLAG = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES*LANE_W-1:0]   chk_bus,
   input  logic [LANES*LANE_W-1:0]   rd_data_in,
   input  logic                      odd_sel,
   input  logic                      gen_en,
   input  logic [LANES-1:0]          lane_en,
   input  logic                      mbox_rd,
   output logic                      perr_n,
   output logic [LANES*LANE_W-1:0]   rd_data_out
);
   localparam int unsigned BUS_W = LANES * LANE_W;
   localparam int unsigned DW    = LANE_W - 1;

   generate
      if (LANE_W < 2) begin : g_bad_width
         $error("lane_parity_unit: LANE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("lane_parity_unit: LANES must be at least 1");
      end
   endgenerate

   logic [LANES-1:0] lane_bad;
   logic             any_bad;
   logic             mask_err;

   genvar k;
   generate
      for (k = 0; k < LANES; k++) begin : g_lane
         lp_lane_check #(.LANE_W(LANE_W)) u_chk (
            .lane_bits (chk_bus[k*LANE_W +: LANE_W]),
            .odd_sel   (odd_sel),
            .lane_used (lane_en[k]),
            .lane_bad  (lane_bad[k])
         );

         lp_lane_gen #(.LANE_W(LANE_W)) u_gen (
            .lane_in  (rd_data_in[k*LANE_W +: LANE_W]),
            .odd_sel  (odd_sel),
            .gen_en   (gen_en),
            .lane_out (rd_data_out[k*LANE_W +: LANE_W])
         );

         // R5: generated lane always carries the selected parity sense
         assert_gen_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gen_en |-> ((^rd_data_out[k*LANE_W +: LANE_W]) == odd_sel));
         // R6: data bits are never touched
         assert_data_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data_out[k*LANE_W +: DW] == rd_data_in[k*LANE_W +: DW]);
      end
   endgenerate

   // The parity trees serve the mailbox generator, so checking is masked.
   always_comb begin
      any_bad  = |lane_bad;
      mask_err = mbox_rd & gen_en;
   end

   lp_flag_stage #(.REG_FLAG(REG_FLAG)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_bad  (any_bad),
      .mask_err (mask_err),
      .flag_n   (perr_n)
   );

   // R6: without generation the read word passes through whole
   assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (rd_data_out == rd_data_in));

   generate
      if (!REG_FLAG) begin : g_comb_chk
         // R7: mailbox read with generation never shows an error
         assert_mbox_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mbox_rd && gen_en) |-> perr_n);
         // R4: with no lane in use there is nothing to report
         assert_no_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en == '0) |-> perr_n);
      end else begin : g_reg_chk
         assert_mbox_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mbox_rd && gen_en) |=> perr_n);
         assert_no_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_en == '0) |=> perr_n);
      end
   endgenerate

   logic unused_w;
   assign unused_w = ^BUS_W[0];
endmodule

// File: tb/lane_parity_unit_tb_top.sv
module lane_parity_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [35:0] chk_bus = '0;
   logic [35:0] rd_data_in = '0;
   logic        odd_sel = 1'b0;
   logic        gen_en = 1'b0;
   logic [3:0]  lane_en = '0;
   logic        mbox_rd = 1'b0;
   logic        perr_n;
   logic        perr_n_reg;
   logic [35:0] rd_data_out;
   logic [35:0] rd_data_out_reg;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lane_parity_unit #(.REG_FLAG(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .chk_bus(chk_bus), .rd_data_in(rd_data_in),
      .odd_sel(odd_sel), .gen_en(gen_en), .lane_en(lane_en), .mbox_rd(mbox_rd),
      .perr_n(perr_n), .rd_data_out(rd_data_out));

   lane_parity_unit #(.REG_FLAG(1'b1)) dut_reg_i (
      .clk(clk), .rst_n(rst_n), .chk_bus(chk_bus), .rd_data_in(rd_data_in),
      .odd_sel(odd_sel), .gen_en(gen_en), .lane_en(lane_en), .mbox_rd(mbox_rd),
      .perr_n(perr_n_reg), .rd_data_out(rd_data_out_reg));

   typedef struct packed {
      logic [35:0] bus;
      logic        odd;
      logic [3:0]  lanes;
      logic        mbox;
      logic        gen;
      logic        exp_n;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{{9'h001, 9'h001, 9'h001, 9'h001}, 1'b1, 4'hF, 1'b0, 1'b0, 1'b1}, // R1 all pass odd
      '{{9'h001, 9'h001, 9'h001, 9'h001}, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0}, // R2 fail even
      '{{9'h001, 9'h001, 9'h001, 9'h000}, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0}, // R3 lane0 bad
      '{{9'h001, 9'h001, 9'h001, 9'h000}, 1'b1, 4'hE, 1'b0, 1'b0, 1'b1}, // R4 lane0 unused
      '{{9'h000, 9'h001, 9'h001, 9'h001}, 1'b1, 4'h7, 1'b0, 1'b0, 1'b1}, // R4 lane3 unused
      '{{9'h000, 9'h001, 9'h001, 9'h001}, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0}, // R3 lane3 bad
      '{{9'h000, 9'h000, 9'h000, 9'h000}, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1}, // R4 no lanes
      '{{9'h000, 9'h000, 9'h000, 9'h000}, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1}, // R7 masked
      '{{9'h000, 9'h000, 9'h000, 9'h000}, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0}, // R7 mbox alone
      '{{9'h000, 9'h000, 9'h000, 9'h000}, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0}, // R7 gen alone
      '{{9'h003, 9'h003, 9'h1FF, 9'h003}, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0}, // R2 lane1 bad
      '{{9'h003, 9'h003, 9'h1FF, 9'h003}, 1'b0, 4'hD, 1'b0, 1'b0, 1'b1}  // R4 lane1 unused
   };

   task automatic check1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic check36(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, check the combinational flag, then the
   // registered one just after the next rising edge.
   task automatic apply(input logic [35:0] bus, input logic odd, input logic [3:0] lanes,
                        input logic mb, input logic gen, input logic exp_n, input string req);
      @(negedge clk);
      chk_bus = bus; odd_sel = odd; lane_en = lanes; mbox_rd = mb; gen_en = gen;
      #1 check1({req, " comb R9"}, perr_n, exp_n);
      @(posedge clk);
      #1 check1({req, " reg R8"}, perr_n_reg, exp_n);
   endtask

   function automatic logic [35:0] gen_model(input logic [35:0] d, input logic odd);
      logic [35:0] r = d;
      for (int k = 0; k < 4; k++) begin
         // Parity bit chosen so the lane's nine-bit ones count matches the sense.
         r[9*k+8] = (($countones(d[9*k +: 8]) % 2) == 1) ? ~odd : odd;
      end
      return r;
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // Reset state: failing input, registered flag held inactive (R8),
      // combinational flag already reporting (R9).
      chk_bus = {4{9'h000}}; odd_sel = 1'b1; lane_en = 4'hF;
      repeat (3) @(posedge clk);
      #1 check1("R8 reset idle", perr_n_reg, 1'b1);
      check1("R9 comb ignores reset", perr_n, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].bus, VECS[i].odd, VECS[i].lanes, VECS[i].mbox, VECS[i].gen,
               VECS[i].exp_n, $sformatf("vec%0d R1 R2 R3", i));
      end

      // Every lane mask, fault mask and parity sense (R1 R2 R3 R4).
      for (int od = 0; od < 2; od++) begin
         for (int lm = 0; lm < 16; lm++) begin
            for (int fm = 0; fm < 16; fm++) begin
               logic [35:0] b;
               logic [8:0]  good;
               good = (od == 1) ? 9'h001 : 9'h003;
               for (int k = 0; k < 4; k++)
                  b[9*k +: 9] = fm[k] ? (good ^ 9'h100) : good;
               apply(b, od[0], lm[3:0], 1'b0, 1'b0, ((fm & lm) == 0),
                     $sformatf("sweep R3 R4 od%0d lm%0h fm%0h", od, lm, fm));
            end
         end
      end

      // Masking with every fault pattern (R7).
      for (int fm = 1; fm < 16; fm++) begin
         logic [35:0] b;
         for (int k = 0; k < 4; k++) b[9*k +: 9] = fm[k] ? 9'h101 : 9'h001;
         apply(b, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1, "R7 mask");
      end

      // Generation and pass-through (R5 R6).
      begin
         logic [35:0] pats [6];
         pats[0] = 36'h0_0000_0000; pats[1] = 36'hF_FFFF_FFFF;
         pats[2] = 36'h1_2345_6789; pats[3] = 36'hA_5A5A_5A5A;
         pats[4] = 36'h8_0402_0100; pats[5] = 36'h7_F3C1_E0FE;
         for (int p = 0; p < 6; p++) begin
            for (int od = 0; od < 2; od++) begin
               @(negedge clk);
               rd_data_in = pats[p]; odd_sel = od[0]; gen_en = 1'b1;
               mbox_rd = 1'b0; lane_en = 4'h0;
               #1 check36("R5 generate", rd_data_out, gen_model(pats[p], od[0]));
               check36("R5 generate reg variant", rd_data_out_reg, gen_model(pats[p], od[0]));
               gen_en = 1'b0;
               #1 check36("R6 pass-through", rd_data_out, pats[p]);
            end
         end
      end

      // Reset mid-run forces the registered flag back to idle (R8).
      @(negedge clk);
      chk_bus = {4{9'h000}}; odd_sel = 1'b1; lane_en = 4'hF; mbox_rd = 1'b0; gen_en = 1'b0;
      @(posedge clk); #1 check1("R8 error before reset", perr_n_reg, 1'b0);
      @(negedge clk) rst_n = 1'b0;
      #1 check1("R8 async reset idle", perr_n_reg, 1'b1);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1 check1("R8 error after reset", perr_n_reg, 1'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule